// File: doc/BRIEF.md
# Result Gain Aligner

This block takes a wide signed accumulation result, such as the output of a two-dimensional convolution, and turns it into a 16-bit signed word. It picks one of four 16-bit windows of the 32-bit value, so that the useful part of the result fills the top of the output word. When the chosen window cannot hold the value, an overflow flag goes high and the output clamps to the signed limit of the right polarity. On every accepted result, a signed comparison against a programmable threshold also sets a one-bit binary flag.

The window can come from a control input, or from automatic selection. In automatic selection the block tracks the largest magnitude seen during a frame. At each frame boundary it picks the window with the most gain that still holds that peak, and it applies that window to the following frame. An intermediate-transfer mode outputs the unscaled 32-bit result over a single clock period, one half in each clock phase. The output bus floats whenever its active-low enable is deasserted.

Top module: `gain_align`

## Requirements
- R1: While `rst_n` is low, `out_data` (with `oe_n` low) reads 0, and `ovf`, `thr_flag`, `out_valid` and `field_out` read 0.
- R2: A result presented with `in_valid` high appears on the outputs one clock edge later, and `out_valid` is high for that cycle. The window code selects these bits: code 0 gives bits [31:16], code 1 gives [27:12], code 2 gives [23:8] and code 3 gives [19:4].
- R3: `ovf` is high exactly when the bits of the input above the selected window's top bit are not all equal to that top bit. Window code 0 never overflows.
- R4: When `ovf` is high, `out_data` is 16'h7FFF for a non-negative input and 16'h8000 for a negative one.
- R5: `thr_flag` is high exactly when the registered input, taken as signed, is strictly greater than `thresh` taken as signed.
- R6: Automatic selection tracks the peak magnitude of accepted samples. On a cycle with `frame_end` high, it chooses the largest code k with peak < 2^(31-4k), or code 0 when no code passes, and shows that code on `field_out` from the next edge. The peak then restarts, and a sample accepted in the `frame_end` cycle belongs to the new frame. While `auto_en` is high, that code, and not `field_sel`, selects the window.
- R7: With `ddr_mode` high, the accepted 32-bit value is output unscaled: bits [15:0] while `clk` is high and bits [31:16] while `clk` is low.
- R8: With `oe_n` high, the block does not drive `out_data`.
- R9: A cycle with `in_valid` low leaves `out_data`, `ovf` and `thr_flag` unchanged and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active, phase also selects the half in intermediate mode |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | 32 | Signed wide result |
| frame_end | input | 1 | Frame boundary pulse for automatic selection |
| field_sel | input | 2 | Manual window code |
| auto_en | input | 1 | Use the automatically chosen window |
| thresh | input | 32 | Signed threshold |
| ddr_mode | input | 1 | Output the unscaled value as two halves per clock |
| oe_n | input | 1 | Active-low output enable |
| out_data | output | 16 | Scaled result or half of the raw value; floats when disabled |
| ovf | output | 1 | Selected window could not hold the value |
| field_out | output | 2 | Window code chosen by automatic selection |
| thr_flag | output | 1 | Result exceeded the threshold |
| out_valid | output | 1 | Outputs were updated this cycle |

## Verification
On every cycle the assertions check the one-cycle valid pipeline, the threshold flag against the signed comparison, the clamp value whenever overflow is flagged, that window code 0 never overflows, and that the chosen code only changes after a frame boundary. The exact window bits, the overflow decisions of the other windows, the peak-based choice from frame to frame, the phase order of the two halves in intermediate mode and the release of the bus can only be shown by the bench's scenarios, which compare against values worked out by hand.

// File: rtl/gain_align_pkg.sv
package gain_align_pkg;

   // Lowest input bit of window f; window 0 sits at the top of the input.
   function automatic int field_lsb(input int in_w, input int out_w,
                                    input int step, input int f);
      return in_w - out_w - step * f;
   endfunction

   // Highest input bit of window f (its sign bit).
   function automatic int field_msb(input int in_w, input int out_w,
                                    input int step, input int f);
      return field_lsb(in_w, out_w, step, f) + out_w - 1;
   endfunction

endpackage

// File: rtl/gain_field_mux.sv
module gain_field_mux
   import gain_align_pkg::*;
#(
   parameter  int IN_W       = 32,
   parameter  int OUT_W      = 16,
   parameter  int STEP       = 4,
   parameter  int NUM_FIELDS = 4,
   localparam int SEL_W      = $clog2(NUM_FIELDS),
   localparam int MIN_LSB    = IN_W - OUT_W - STEP * (NUM_FIELDS - 1)
) (
   input  logic [IN_W-1:0]  din,
   input  logic [SEL_W-1:0] sel,
   output logic [OUT_W-1:0] dout,
   output logic             ovf
);

   logic [OUT_W-1:0]      cand [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] fits;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      localparam int LSB = field_lsb(IN_W, OUT_W, STEP, f);
      localparam int MSB = field_msb(IN_W, OUT_W, STEP, f);
      assign cand[f] = din[MSB:LSB];
      if (MSB == IN_W - 1) begin : g_top
         assign fits[f] = 1'b1;
      end else begin : g_lower
         logic [IN_W-MSB-1:0] hi;
         assign hi      = din[IN_W-1:MSB];
         assign fits[f] = (&hi) | ~(|hi);
      end
   end

   if (MIN_LSB > 0) begin : g_sink
      logic unused_low;
      assign unused_low = ^din[MIN_LSB-1:0];
   end

   always_comb begin
      if (fits[sel]) begin
         dout = cand[sel];
         ovf  = 1'b0;
      end else begin
         ovf  = 1'b1;
         dout = din[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                            : {1'b0, {(OUT_W-1){1'b1}}};
      end
   end

endmodule

// File: rtl/gain_auto_sel.sv
module gain_auto_sel
   import gain_align_pkg::*;
#(
   parameter  int IN_W       = 32,
   parameter  int OUT_W      = 16,
   parameter  int STEP       = 4,
   parameter  int NUM_FIELDS = 4,
   localparam int SEL_W      = $clog2(NUM_FIELDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [IN_W-1:0]  din,
   input  logic             frame_end,
   output logic [SEL_W-1:0] pick_q
);

   logic [IN_W-1:0]  mag;
   logic [IN_W-1:0]  peak_q;
   logic [SEL_W-1:0] pick_d;

   // Magnitude; the most negative value maps to 2^(IN_W-1), still unsigned-exact.
   assign mag = din[IN_W-1] ? (~din + 1'b1) : din;

   // Largest window code whose sign bit position still bounds the peak.
   always_comb begin
      pick_d = '0;
      for (int f = 0; f < NUM_FIELDS; f++) begin
         if (peak_q < (IN_W'(1) << field_msb(IN_W, OUT_W, STEP, f)))
            pick_d = SEL_W'(f);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         peak_q <= '0;
         pick_q <= '0;
      end else if (frame_end) begin
         pick_q <= pick_d;
         peak_q <= smp_valid ? mag : '0;
      end else if (smp_valid && (mag > peak_q)) begin
         peak_q <= mag;
      end
   end

endmodule

// File: rtl/gain_align.sv
module gain_align
   import gain_align_pkg::*;
#(
   parameter  int IN_W       = 32,
   parameter  int OUT_W      = 16,
   parameter  int STEP       = 4,
   parameter  int NUM_FIELDS = 4,
   parameter  bit DDR_EN     = 1'b1,
   localparam int SEL_W      = $clog2(NUM_FIELDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   input  logic             frame_end,
   input  logic [SEL_W-1:0] field_sel,
   input  logic             auto_en,
   input  logic [IN_W-1:0]  thresh,
   input  logic             ddr_mode,
   input  logic             oe_n,
   output wire  [OUT_W-1:0] out_data,
   output logic             ovf,
   output logic [SEL_W-1:0] field_out,
   output logic             thr_flag,
   output logic             out_valid
);

   // Elaboration-time parameter checks
   if (STEP < 1) begin : g_chk_step
      $error("gain_align: STEP must be at least 1");
   end
   if (OUT_W + STEP * (NUM_FIELDS - 1) > IN_W) begin : g_chk_span
      $error("gain_align: lowest window falls below bit 0");
   end
   if (NUM_FIELDS < 2 || NUM_FIELDS != (1 << SEL_W)) begin : g_chk_nf
      $error("gain_align: NUM_FIELDS must be a power of two, at least 2");
   end
   if (DDR_EN && (IN_W != 2 * OUT_W)) begin : g_chk_ddr
      $error("gain_align: split transfer needs IN_W == 2*OUT_W");
   end

   logic [SEL_W-1:0] auto_pick;
   logic [SEL_W-1:0] eff_sel;
   logic [OUT_W-1:0] scaled_d;
   logic             ovf_d;
   logic             thr_d;
   logic [OUT_W-1:0] scaled_q;
   logic [OUT_W-1:0] bus_val;

   gain_auto_sel #(
      .IN_W(IN_W), .OUT_W(OUT_W), .STEP(STEP), .NUM_FIELDS(NUM_FIELDS)
   ) u_auto (
      .clk(clk), .rst_n(rst_n), .smp_valid(in_valid), .din(in_data),
      .frame_end(frame_end), .pick_q(auto_pick)
   );

   assign eff_sel = auto_en ? auto_pick : field_sel;

   gain_field_mux #(
      .IN_W(IN_W), .OUT_W(OUT_W), .STEP(STEP), .NUM_FIELDS(NUM_FIELDS)
   ) u_mux (
      .din(in_data), .sel(eff_sel), .dout(scaled_d), .ovf(ovf_d)
   );

   assign thr_d = $signed(in_data) > $signed(thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scaled_q  <= '0;
         ovf       <= 1'b0;
         thr_flag  <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            scaled_q <= scaled_d;
            ovf      <= ovf_d;
            thr_flag <= thr_d;
         end
      end
   end

   assign field_out = auto_pick;

   if (DDR_EN) begin : g_ddr
      logic [IN_W-1:0] raw_q;
      always_ff @(posedge clk) begin
         if (!rst_n)        raw_q <= '0;
         else if (in_valid) raw_q <= in_data;
      end
      // Low half in the high clock phase, high half in the low phase.
      assign bus_val = !ddr_mode ? scaled_q
                     : (clk ? raw_q[OUT_W-1:0] : raw_q[IN_W-1:OUT_W]);
   end else begin : g_plain
      logic unused_ddr;
      assign unused_ddr = ddr_mode;
      assign bus_val    = scaled_q;
   end

   assign out_data = oe_n ? {OUT_W{1'bz}} : bus_val;

endmodule

// File: rtl/gain_align_chk.sv
module gain_align_chk #(
   parameter int IN_W  = 32,
   parameter int OUT_W = 16,
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [IN_W-1:0]  in_data,
   input logic             frame_end,
   input logic [SEL_W-1:0] field_sel,
   input logic             auto_en,
   input logic [IN_W-1:0]  thresh,
   input logic             ddr_mode,
   input logic             oe_n,
   input wire  [OUT_W-1:0] out_data,
   input logic             ovf,
   input logic [SEL_W-1:0] field_out,
   input logic             thr_flag,
   input logic             out_valid
);

   localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_thr_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ($signed(in_data) > $signed(thresh)) |=> thr_flag);

   assert_thr_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !($signed(in_data) > $signed(thresh)) |=> !thr_flag);

   assert_clamp_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf && !ddr_mode && !oe_n |-> (out_data == POS_LIM || out_data == NEG_LIM));

   assert_top_field_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !auto_en && (field_sel == '0) |=> !ovf);

   assert_pick_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(field_out));

endmodule

bind gain_align gain_align_chk #(
   .IN_W(IN_W), .OUT_W(OUT_W), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/gain_align_test.sv
module gain_align_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        frame_end = 1'b0;
   logic [1:0]  field_sel = '0;
   logic        auto_en = 1'b0;
   logic [31:0] thresh = 32'h0001_0000;
   logic        ddr_mode = 1'b0;
   logic        oe_n = 1'b0;
   logic        tb_drive = 1'b0;
   wire  [15:0] bus;
   logic        ovf, thr_flag, out_valid;
   logic [1:0]  field_out;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;   // 50 MHz

   assign bus = tb_drive ? 16'h5A5A : 16'hzzzz;

   gain_align uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .frame_end(frame_end), .field_sel(field_sel), .auto_en(auto_en),
      .thresh(thresh), .ddr_mode(ddr_mode), .oe_n(oe_n), .out_data(bus),
      .ovf(ovf), .field_out(field_out), .thr_flag(thr_flag),
      .out_valid(out_valid)
   );

   // data, window code, expected out, expected ovf, expected thr (thresh 0x10000)
   localparam logic [51:0] VEC [0:9] = '{
      {32'h1234_5678, 2'd0, 16'h1234, 1'b0, 1'b1},
      {32'h0001_2345, 2'd1, 16'h0012, 1'b0, 1'b1},
      {32'h0001_2345, 2'd3, 16'h1234, 1'b0, 1'b1},
      {32'h0010_0000, 2'd3, 16'h7FFF, 1'b1, 1'b1},
      {32'hFFFF_8000, 2'd3, 16'hF800, 1'b0, 1'b0},
      {32'hF000_0000, 2'd2, 16'h8000, 1'b1, 1'b0},
      {32'h8000_0000, 2'd0, 16'h8000, 1'b0, 1'b0},
      {32'h7FFF_FFFF, 2'd1, 16'h7FFF, 1'b1, 1'b1},
      {32'h0080_1234, 2'd2, 16'h7FFF, 1'b1, 1'b1},
      {32'hFF80_1234, 2'd2, 16'h8012, 1'b0, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Present one sample; returns 5 ns after the capturing edge (clk high).
   task automatic push(input logic [31:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      @(posedge clk);
      #5;
   endtask

   // One frame_end pulse without a sample; returns after the capturing edge.
   task automatic frame_pulse();
      @(negedge clk);
      in_valid  = 1'b0;
      frame_end = 1'b1;
      @(posedge clk);
      #5;
      frame_end = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [1:0]  s;
      logic [15:0] eo;
      logic        ev, et;

      // R1: reset state
      repeat (3) @(posedge clk);
      #5;
      chk("R1 out_data", {16'h0, bus}, 32'h0);
      chk("R1 flags", {28'h0, ovf, thr_flag, out_valid, 1'b0}, 32'h0);
      chk("R1 field_out", {30'h0, field_out}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2/R3/R4/R5: vector table, manual window selection
      foreach (VEC[i]) begin
         {d, s, eo, ev, et} = VEC[i];
         field_sel = s;
         push(d);
         chk(ev ? "R4 clamp" : "R2 window", {16'h0, bus}, {16'h0, eo});
         chk("R3 ovf", {31'h0, ovf}, {31'h0, ev});
         chk("R5 thr", {31'h0, thr_flag}, {31'h0, et});
         chk("R2 out_valid", {31'h0, out_valid}, 32'h1);
      end

      // R9: idle cycle holds outputs
      field_sel = 2'd0;
      push(32'h1234_5678);
      @(negedge clk);
      in_valid  = 1'b0;
      in_data   = 32'h7FFF_FFFF;
      field_sel = 2'd3;
      @(posedge clk);
      #5;
      chk("R9 hold data", {16'h0, bus}, 32'h1234);
      chk("R9 hold ovf", {31'h0, ovf}, 32'h0);
      chk("R9 hold thr", {31'h0, thr_flag}, 32'h1);
      chk("R9 valid low", {31'h0, out_valid}, 32'h0);

      // R8: bus released, other driver visible; then driven again
      @(negedge clk);
      oe_n     = 1'b1;
      tb_drive = 1'b1;
      #2;
      chk("R8 released", {16'h0, bus}, 32'h5A5A);
      tb_drive = 1'b0;
      oe_n     = 1'b0;
      #2;
      chk("R8 driven", {16'h0, bus}, 32'h1234);

      // R6: automatic selection, field_sel left at 0 to show it is overridden
      auto_en   = 1'b1;
      field_sel = 2'd0;
      frame_pulse();                       // peak 2^31 from the table
      chk("R6 peak 2^31", {30'h0, field_out}, 32'd0);
      push(32'h0000_0900);
      push(32'hFFFF_F000);
      frame_pulse();                       // peak 0x1000 -> code 3
      chk("R6 small peak", {30'h0, field_out}, 32'd3);
      push(32'h0000_0900);
      chk("R6 applied code 3", {16'h0, bus}, 32'h0090);
      push(32'hFFE0_0000);                 // code 3 overflows, negative
      chk("R6 applied ovf", {16'h0, bus}, 32'h8000);
      frame_pulse();                       // peak 2^21 -> code 2
      chk("R6 peak 2^21", {30'h0, field_out}, 32'd2);
      push(32'hFFE0_0000);
      chk("R6 code 2 fits", {16'h0, bus}, 32'hE000);
      push(32'h0500_0000);
      chk("R6 code 2 clamp", {16'h0, bus}, 32'h7FFF);
      frame_pulse();                       // peak 0x05000000 -> code 1
      chk("R6 peak code 1", {30'h0, field_out}, 32'd1);
      push(32'h4000_0000);
      frame_pulse();                       // peak 2^30 -> code 0
      chk("R6 peak code 0", {30'h0, field_out}, 32'd0);
      frame_pulse();                       // empty frame -> code 3
      chk("R6 empty frame", {30'h0, field_out}, 32'd3);

      // R7: split raw transfer
      auto_en  = 1'b0;
      ddr_mode = 1'b1;
      push(32'hA5A5_3C3C);
      chk("R7 high phase low half", {16'h0, bus}, 32'h3C3C);
      #10;
      chk("R7 low phase high half", {16'h0, bus}, 32'hA5A5);
      @(negedge clk);
      in_valid = 1'b0;
      ddr_mode = 1'b0;
      repeat (2) @(posedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule